// File: doc/BRIEF.md
# Mux-Select Programmable Logic Cell

This block is a fine-grained configurable logic cell. It is meant to be placed many times across a fabric. Its combinational core is a four-way multiplexer. The two select lines of that multiplexer are not driven directly. Each select comes from a fixed gate fed by two inputs:

- The low select is the AND of `a0_i` and `b0_i`.
- The high select is the OR of `a1_i` and `b1_i`.

With this arrangement a single cell can implement a wide range of functions of up to eight inputs.

A sequential stage follows the multiplexer, and a static configuration chooses its form. It can be an edge-triggered flip-flop with clear, a transparent latch without clear, a transparent latch with clear, or a plain wire that leaves the cell purely combinational. The configuration is taken from `cfg_i` only while the cell is held in reset. The data path is `DW` bits wide, and all bits share the select logic, the clock or gate pin and the clear pin.

Top module: `mlc_cell`

## Requirements
- R1: The low select bit is the logical AND of `a0_i` and `b0_i`.
- R2: The high select bit is the logical OR of `a1_i` and `b1_i`.
- R3: The multiplexer output is `d00_i` for selects {high,low}=00, `d01_i` for 01, `d10_i` for 10 and `d11_i` for 11.
- R4: `cfg_i` is captured on each rising `clk_i` edge while `rst_n_i` is low, and changes after reset release have no effect. The encoding is: 00 = flip-flop with clear, 01 = latch, 10 = latch with clear, 11 = pass-through.
- R5: While `rst_n_i` is low the stored value is 0. In every registered mode, `y_o` is 0 after reset release until new data is stored.
- R6: In flip-flop mode, `y_o` takes the multiplexer value at each rising `clk_i` edge and holds it between edges.
- R7: In flip-flop mode, a low `clr_n_i` forces `y_o` to 0 at once, without waiting for a clock edge, and keeps it at 0 across clock edges while low.
- R8: In latch mode (01), `y_o` follows the multiplexer while `clk_i` is high and holds the last value while `clk_i` is low.
- R9: In latch mode (01), `clr_n_i` has no effect on `y_o`.
- R10: In latch-with-clear mode (10), `y_o` follows the multiplexer while `clk_i` is high and holds it while `clk_i` is low. A low `clr_n_i` forces 0 at once and takes priority over an open gate.
- R11: In pass-through mode, `y_o` equals the multiplexer output regardless of `clk_i` and `clr_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Flip-flop clock, or latch gate (open when high) |
| rst_n_i | input | 1 | Active-low reset; clears storage and samples the configuration |
| clr_n_i | input | 1 | Active-low asynchronous clear of the stored value |
| cfg_i | input | 2 | Sequential stage selection, sampled in reset |
| d00_i | input | DW | Data chosen for selects 00 |
| d01_i | input | DW | Data chosen for selects 01 |
| d10_i | input | DW | Data chosen for selects 10 |
| d11_i | input | DW | Data chosen for selects 11 |
| a0_i | input | 1 | First input of the AND forming the low select |
| b0_i | input | 1 | Second input of the AND forming the low select |
| a1_i | input | 1 | First input of the OR forming the high select |
| b1_i | input | 1 | Second input of the OR forming the high select |
| y_o | output | DW | Cell output |

## Verification
In each of the four modes, all 256 combinations of the four data bits and four select inputs are applied. Together these sweeps separate an AND select from an OR select, and they catch any swap of data legs or of select significance.

Registered modes also get a differing pattern between the capture point and the sample point, which shows whether the output holds or leaks through. Clear is pulsed with the gate shut, with the gate open and across clock edges, which separates the two latch flavours from each other and from the flip-flop. The configuration pins are driven to a different mode after reset, so any live use of them would break the mode-specific checks.

// File: rtl/mlc_pkg.sv
`timescale 1ns/1ps
package mlc_pkg;

  typedef enum logic [1:0] {
    MODE_FF        = 2'b00,
    MODE_LATCH     = 2'b01,
    MODE_LATCH_CLR = 2'b10,
    MODE_PASS      = 2'b11
  } mlc_mode_e;

  localparam int SEL_W = 2;
  localparam int LEGS  = 1 << SEL_W;

  // low select: both inputs must be high
  function automatic logic sel_lo_f(input logic a, input logic b);
    return a & b;
  endfunction

  // high select: either input high
  function automatic logic sel_hi_f(input logic a, input logic b);
    return a | b;
  endfunction

  // legs packed as {d11,d10,d01,d00}; sel = {hi,lo}
  function automatic logic mux4_f(input logic [LEGS-1:0] legs,
                                  input logic [SEL_W-1:0] sel);
    return legs[sel];
  endfunction

  function automatic logic has_clear_f(input mlc_mode_e m);
    return (m == MODE_FF) || (m == MODE_LATCH_CLR);
  endfunction

  function automatic logic is_latch_f(input mlc_mode_e m);
    return (m == MODE_LATCH) || (m == MODE_LATCH_CLR);
  endfunction

endpackage

// File: rtl/mlc_select.sv
`timescale 1ns/1ps
module mlc_select
  import mlc_pkg::*;
(
  input  logic             a0_i,
  input  logic             b0_i,
  input  logic             a1_i,
  input  logic             b1_i,
  output logic [SEL_W-1:0] sel_o
);

  logic sel_lo;
  logic sel_hi;

  assign sel_lo = sel_lo_f(a0_i, b0_i);
  assign sel_hi = sel_hi_f(a1_i, b1_i);
  assign sel_o  = {sel_hi, sel_lo};

endmodule

// File: rtl/mlc_mux4.sv
`timescale 1ns/1ps
module mlc_mux4
  import mlc_pkg::*;
#(
  parameter int DW = 1
) (
  input  logic [DW-1:0]    d00_i,
  input  logic [DW-1:0]    d01_i,
  input  logic [DW-1:0]    d10_i,
  input  logic [DW-1:0]    d11_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [DW-1:0]    out_o
);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic [LEGS-1:0] legs;
    assign legs     = {d11_i[i], d10_i[i], d01_i[i], d00_i[i]};
    assign out_o[i] = mux4_f(legs, sel_i);
  end

endmodule

// File: rtl/mlc_store.sv
`timescale 1ns/1ps
module mlc_store
  import mlc_pkg::*;
#(
  parameter int DW = 1
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          clr_n_i,
  input  mlc_mode_e     mode_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] q_o
);

  logic [DW-1:0] ff_q;
  logic [DW-1:0] lat_q;
  logic          ff_arst_n;
  logic          lat_clear;
  logic          lat_open;

  assign ff_arst_n = rst_n_i & clr_n_i;
  assign lat_clear = !rst_n_i || (!clr_n_i && (mode_i == MODE_LATCH_CLR));
  assign lat_open  = clk_i && is_latch_f(mode_i);

  always_ff @(posedge clk_i or negedge ff_arst_n) begin
    if (!ff_arst_n)
      ff_q <= '0;
    else if (mode_i == MODE_FF)
      ff_q <= din_i;
  end

  always_latch begin
    if (lat_clear)
      lat_q = '0;
    else if (lat_open)
      lat_q = din_i;
  end

  always_comb begin
    unique case (mode_i)
      MODE_FF:        q_o = ff_q;
      MODE_LATCH,
      MODE_LATCH_CLR: q_o = lat_q;
      default:        q_o = din_i;
    endcase
  end

endmodule

// File: rtl/mlc_cell.sv
`timescale 1ns/1ps
module mlc_cell
  import mlc_pkg::*;
#(
  parameter int DW = 1
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          clr_n_i,
  input  logic [1:0]    cfg_i,
  input  logic [DW-1:0] d00_i,
  input  logic [DW-1:0] d01_i,
  input  logic [DW-1:0] d10_i,
  input  logic [DW-1:0] d11_i,
  input  logic          a0_i,
  input  logic          b0_i,
  input  logic          a1_i,
  input  logic          b1_i,
  output logic [DW-1:0] y_o
);

  mlc_mode_e        mode_q;
  logic [SEL_W-1:0] sel;
  logic [DW-1:0]    mux_o;

  // configuration is loaded only while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_n_i)
      mode_q <= mlc_mode_e'(cfg_i);
  end

  mlc_select u_sel (
    .a0_i  (a0_i),
    .b0_i  (b0_i),
    .a1_i  (a1_i),
    .b1_i  (b1_i),
    .sel_o (sel)
  );

  mlc_mux4 #(.DW(DW)) u_mux (
    .d00_i (d00_i),
    .d01_i (d01_i),
    .d10_i (d10_i),
    .d11_i (d11_i),
    .sel_i (sel),
    .out_o (mux_o)
  );

  mlc_store #(.DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .clr_n_i (clr_n_i),
    .mode_i  (mode_q),
    .din_i   (mux_o),
    .q_o     (y_o)
  );

endmodule

// File: rtl/mlc_cell_chk.sv
`timescale 1ns/1ps
module mlc_cell_chk
  import mlc_pkg::*;
#(
  parameter int DW = 1
) (
  input logic          clk_i,
  input logic          rst_n_i,
  input logic          clr_n_i,
  input mlc_mode_e     mode_q,
  input logic [DW-1:0] mux_o,
  input logic [DW-1:0] y_o
);

  // R4: mode stays fixed once reset is released
  assert_mode_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $past(rst_n_i) |-> $stable(mode_q));

  // R6: flip-flop output equals the mux value sampled at the prior edge
  assert_ff_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_q == MODE_FF && clr_n_i) ##1 clr_n_i |-> y_o == $past(mux_o));

  // R7: clear holds the flip-flop at zero
  assert_ff_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_q == MODE_FF && !clr_n_i) |-> y_o == '0);

  // R8: open gate makes the plain latch follow the mux
  assert_latch_follow_R8: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    (mode_q == MODE_LATCH) |-> y_o == mux_o);

  // R10: clear wins in the clearable latch
  assert_latch_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_q == MODE_LATCH_CLR && !clr_n_i) |-> y_o == '0);

  // R11: pass-through output equals the mux
  assert_pass_R11: assert property (@(negedge clk_i) disable iff (!rst_n_i)
    (mode_q == MODE_PASS) |-> y_o == mux_o);

endmodule

bind mlc_cell mlc_cell_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_n_i (rst_n_i),
  .clr_n_i (clr_n_i),
  .mode_q  (mode_q),
  .mux_o   (mux_o),
  .y_o     (y_o)
);

// File: tb/sim_mlc_cell.sv
`timescale 1ns/1ps
module sim_mlc_cell;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_n = 1'b1;
  logic [1:0] cfg = 2'b00;
  logic       d00 = 0, d01 = 0, d10 = 0, d11 = 0;
  logic       a0 = 0, b0 = 0, a1 = 0, b1 = 0;
  logic [0:0] y;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  mlc_cell #(.DW(1)) u0 (
    .clk_i (clk), .rst_n_i (rst_n), .clr_n_i (clr_n), .cfg_i (cfg),
    .d00_i (d00), .d01_i (d01), .d10_i (d10), .d11_i (d11),
    .a0_i (a0), .b0_i (b0), .a1_i (a1), .b1_i (b1),
    .y_o (y)
  );

  // v[3:0] = {d11,d10,d01,d00}; v[4]=a0 v[5]=b0 v[6]=a1 v[7]=b1
  function automatic logic ref_y(input logic [7:0] v);
    logic hi, lo;
    hi = v[6] | v[7];
    lo = v[4] & v[5];
    if (hi && lo) return v[3];
    if (hi)       return v[2];
    if (lo)       return v[1];
    return v[0];
  endfunction

  task automatic apply(input logic [7:0] v);
    {d11, d10, d01, d00} = v[3:0];
    a0 = v[4]; b0 = v[5]; a1 = v[6]; b1 = v[7];
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: y=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    #5 clk = 1'b1;
    #5 clk = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; clr_n = 1'b1; clk = 1'b0; cfg = m;
    apply(8'h0F);
    tick(); tick();
    #1;
    if (m != 2'b11) chk("R5 reset clears storage", y[0], 1'b0);
    rst_n = 1'b1;
    #1 cfg = ~m;  // R4: ignored after release
    apply(8'h00);
    #1;
    if (m != 2'b11) chk("R5 zero after release", y[0], 1'b0);
  endtask

  initial begin
    logic prev;
    // ---------- flip-flop mode ----------
    do_reset(2'b00);
    prev = 1'b0;
    for (int v = 0; v < 256; v++) begin
      apply(v[7:0]);
      #2 chk("R6 hold before edge (R4)", y[0], prev);
      #3 clk = 1'b1;
      #2 chk("R6 capture R1 R2 R3", y[0], ref_y(v[7:0]));
      prev = ref_y(v[7:0]);
      #3 clk = 1'b0;
    end
    apply(8'h0F);
    tick(); #1 chk("R6 load one", y[0], 1'b1);
    clr_n = 1'b0;
    #1 chk("R7 async clear", y[0], 1'b0);
    tick(); #1 chk("R7 clear across edge", y[0], 1'b0);
    clr_n = 1'b1;
    #1 chk("R7 stays zero after clear", y[0], 1'b0);
    tick(); #1 chk("R6 reload after clear", y[0], 1'b1);

    // ---------- plain latch ----------
    do_reset(2'b01);
    for (int v = 0; v < 256; v++) begin
      apply(v[7:0]);
      clk = 1'b1;
      #2 chk("R8 follow R1 R2 R3", y[0], ref_y(v[7:0]));
      clk = 1'b0;
      #1 apply(v[7:0] ^ 8'h0F);
      #2 chk("R8 hold gate low", y[0], ref_y(v[7:0]));
      #5;
    end
    apply(8'h0F); clk = 1'b1; #2 clk = 1'b0;
    #1 clr_n = 1'b0;
    #1 chk("R9 clear ignored gate low", y[0], 1'b1);
    apply(8'h00); clk = 1'b1;
    #1 chk("R9 follows with clear low", y[0], 1'b0);
    apply(8'h0F);
    #1 chk("R9 follows one with clear low", y[0], 1'b1);
    clk = 1'b0; clr_n = 1'b1; #4;

    // ---------- latch with clear ----------
    do_reset(2'b10);
    for (int v = 0; v < 256; v++) begin
      apply(v[7:0]);
      clk = 1'b1;
      #2 chk("R10 follow R1 R2 R3", y[0], ref_y(v[7:0]));
      clk = 1'b0;
      #1 apply(v[7:0] ^ 8'h0F);
      #2 chk("R10 hold gate low", y[0], ref_y(v[7:0]));
      #5;
    end
    apply(8'h0F); clk = 1'b1;
    #1 chk("R10 open gate one", y[0], 1'b1);
    clr_n = 1'b0;
    #1 chk("R10 clear beats open gate", y[0], 1'b0);
    clk = 1'b0;
    #1 clr_n = 1'b1;
    #1 chk("R10 zero held after clear", y[0], 1'b0);
    clk = 1'b1;
    #1 chk("R10 reopen follows", y[0], 1'b1);
    clk = 1'b0;
    #1 clr_n = 1'b0;
    #1 chk("R10 clear gate low", y[0], 1'b0);
    clr_n = 1'b1; #4;

    // ---------- pass-through ----------
    do_reset(2'b11);
    for (int v = 0; v < 256; v++) begin
      apply(v[7:0]);
      clr_n = v[0] ^ v[5];
      #2 chk("R11 pass R1 R2 R3", y[0], ref_y(v[7:0]));
      clk = 1'b1;
      #2 chk("R11 pass gate high", y[0], ref_y(v[7:0]));
      #3 clk = 1'b0;
      #3;
    end
    clr_n = 1'b1;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule